// File: doc/BRIEF.md
# Associative Memory Road Matcher

This block is a content-addressable pattern bank for a tracking trigger. It stores a fixed set of patterns. Each pattern holds one coarse-resolution word for every detector layer. During an event, hit words arrive one per cycle on a shared bus with a layer select. Every pattern compares the hit against its own word for that layer in the same cycle. A matching layer sets a hit flag, and that flag stays set until the event is closed.

A pattern becomes a road once the number of its flagged layers reaches a programmable threshold. The threshold may be all six layers, or a relaxed majority of five or four. Roads are available as soon as the clock edge that accepts the last hit has passed. They are drained one at a time through a lowest-address-first encoder, and each pop retires the road currently presented. An end-of-event command clears all flags and retirements in one cycle and leaves the stored words untouched. A load path writes single pattern words and reads them back, using the same pattern address.

Top module: `am_road_matcher`

## Requirements
- R1: After reset, empty_o is 1, road_valid_o is 0, data_o is 0 and the match threshold is 6.
- R2: Opcode 1 (write) stores data_i in layer sel_i of pattern addr_i. Opcode 2 (read) loads data_o with that word at the next edge, and data_o then holds until the next read.
- R3: Opcode 3 (hit) compares data_i only against layer sel_i of every pattern. An equal word on any other layer sets no flag.
- R4: Hit flags persist across idle, read and write cycles. Repeated hits on one layer count that layer once. Road outputs change only on hit, pop, threshold or end-of-event commands.
- R5: A pattern is a road when its count of flagged layers is at least the threshold. With the default threshold of 6, five flagged layers give no road.
- R6: Opcode 6 (threshold) loads data_i[2:0] as the new threshold when that value is 4, 5 or 6. Any other value is ignored. The threshold applies at once to the flags already held.
- R7: road_addr_o presents the lowest-addressed road that has not been retired, and road_valid_o is 1 while such a road exists.
- R8: Opcode 5 (pop) retires the presented road. empty_o is 1 exactly when no unretired road remains.
- R9: Opcode 4 (end of event) clears all hit flags and retirements in one cycle, and stored words keep their values.
- R10: A single hit sets flags in every pattern whose word for that layer equals it, in the same cycle.
- R11: A sel_i value of 6 or 7 makes write and hit commands do nothing, and a read with such a select returns 0.
- R12: A road whose last needed layer arrives in a hit command is visible on road_valid_o and road_addr_o right after the edge that accepts that hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Command: 0 idle, 1 write, 2 read, 3 hit, 4 end of event, 5 pop, 6 threshold |
| addr_i | input | 7 | Pattern address for write and read |
| sel_i | input | 3 | Layer select |
| data_i | input | 12 | Hit word, word to write, or threshold value |
| data_o | output | 12 | Read-back word |
| road_valid_o | output | 1 | An unretired road exists |
| road_addr_o | output | 7 | Address of the lowest unretired road |
| empty_o | output | 1 | No unretired road remains |

## Verification
Every command takes effect at one clock edge. Hit, pop, threshold and end-of-event results appear on the road outputs straight after that edge, because those outputs decode registered flags with no extra register. Read data appears on data_o after that same edge and then holds. The bench applies each command at a falling edge and returns it to idle at the next falling edge. It therefore samples exactly one rising edge after the command, and a result that lagged by one more cycle would be caught.

// File: rtl/am_pkg.sv
package am_pkg;
  typedef enum logic [3:0] {
    OP_IDLE  = 4'd0,
    OP_WRITE = 4'd1,
    OP_READ  = 4'd2,
    OP_HIT   = 4'd3,
    OP_EOE   = 4'd4,
    OP_POP   = 4'd5,
    OP_THR   = 4'd6
  } op_e;
endpackage

// File: rtl/am_pattern_slot.sv
module am_pattern_slot #(
  parameter int N_LAYER = 6,
  parameter int WORD_W  = 12,
  parameter int SEL_W   = 3,
  localparam int CNT_W  = $clog2(N_LAYER + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              hit_en_i,
  input  logic              clr_i,
  input  logic              pop_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [CNT_W-1:0]  thr_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              road_o
);
  logic [WORD_W-1:0]  words_q [N_LAYER];
  logic [N_LAYER-1:0] flags_q;
  logic               done_q;
  logic [CNT_W-1:0]   cnt;

  for (genvar l = 0; l < N_LAYER; l++) begin : g_layer
    logic sel_hit;
    assign sel_hit = (sel_i == SEL_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_q[l] <= '0;
      end else if (wr_en_i && sel_hit) begin
        words_q[l] <= data_i;
      end
    end

    // per-layer comparator; flag holds until end of event
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q[l] <= 1'b0;
      end else if (clr_i) begin
        flags_q[l] <= 1'b0;
      end else if (hit_en_i && sel_hit && (words_q[l] == data_i)) begin
        flags_q[l] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
    end else if (clr_i) begin
      done_q <= 1'b0;
    end else if (pop_i) begin
      done_q <= 1'b1;
    end
  end

  always_comb begin
    cnt = '0;
    for (int l = 0; l < N_LAYER; l++) cnt = cnt + CNT_W'(flags_q[l]);
  end

  always_comb begin
    rd_word_o = '0;
    for (int l = 0; l < N_LAYER; l++) begin
      if (sel_i == SEL_W'(l)) rd_word_o = words_q[l];
    end
  end

  assign road_o = (cnt >= thr_i) && !done_q;
endmodule

// File: rtl/am_prio_encoder.sv
module am_prio_encoder #(
  parameter int N      = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;

  always_comb begin
    grant_o = '0;
    if (valid_o) grant_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/am_road_matcher.sv
module am_road_matcher
  import am_pkg::*;
#(
  parameter int N_PAT   = 128,
  parameter int N_LAYER = 6,
  parameter int WORD_W  = 12,
  parameter int MIN_THR = 4,
  localparam int ADDR_W = $clog2(N_PAT),
  localparam int SEL_W  = 3,
  localparam int CNT_W  = $clog2(N_LAYER + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              road_valid_o,
  output logic [ADDR_W-1:0] road_addr_o,
  output logic              empty_o
);
  logic [CNT_W-1:0]  thr_q;
  logic [CNT_W-1:0]  thr_new;
  logic [N_PAT-1:0]  road_vec;
  logic [N_PAT-1:0]  grant;
  logic [WORD_W-1:0] rd_words [N_PAT];
  logic              is_wr, is_hit, is_clr, is_pop, is_rd, is_thr;

  assign is_wr  = (op_i == OP_WRITE);
  assign is_rd  = (op_i == OP_READ);
  assign is_hit = (op_i == OP_HIT);
  assign is_clr = (op_i == OP_EOE);
  assign is_pop = (op_i == OP_POP);
  assign is_thr = (op_i == OP_THR);
  assign thr_new = data_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= CNT_W'(N_LAYER);
    end else if (is_thr && (thr_new >= CNT_W'(MIN_THR)) && (thr_new <= CNT_W'(N_LAYER))) begin
      thr_q <= thr_new;
    end
  end

  for (genvar p = 0; p < N_PAT; p++) begin : g_pat
    am_pattern_slot #(
      .N_LAYER (N_LAYER),
      .WORD_W  (WORD_W),
      .SEL_W   (SEL_W)
    ) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (is_wr && (addr_i == ADDR_W'(p))),
      .hit_en_i  (is_hit),
      .clr_i     (is_clr),
      .pop_i     (is_pop && grant[p]),
      .sel_i     (sel_i),
      .data_i    (data_i),
      .thr_i     (thr_q),
      .rd_word_o (rd_words[p]),
      .road_o    (road_vec[p])
    );
  end

  am_prio_encoder #(.N(N_PAT)) i_enc (
    .req_i   (road_vec),
    .valid_o (road_valid_o),
    .idx_o   (road_addr_o),
    .grant_o (grant)
  );

  assign empty_o = !road_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
    end else if (is_rd) begin
      data_o <= rd_words[addr_i];
    end
  end
endmodule

// File: rtl/am_road_matcher_chk.sv
module am_road_matcher_chk #(
  parameter int ADDR_W  = 7,
  parameter int CNT_W   = 3,
  parameter int N_LAYER = 6,
  parameter int MIN_THR = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic              road_valid_o,
  input logic [ADDR_W-1:0] road_addr_o,
  input logic              empty_o,
  input logic [CNT_W-1:0]  thr_q
);
  AST_POP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (road_valid_o && op_i == 4'd5) |=> (!road_valid_o || road_addr_o > $past(road_addr_o))); // R7

  AST_EOE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4) |=> empty_o); // R9

  AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 || op_i == 4'd1 || op_i == 4'd2) |=> ($stable(road_valid_o) && $stable(road_addr_o))); // R4

  AST_THR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q >= CNT_W'(MIN_THR)) && (thr_q <= CNT_W'(N_LAYER))); // R6

  AST_POP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && op_i == 4'd5) |=> empty_o); // R8
endmodule

bind am_road_matcher am_road_matcher_chk #(
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W),
  .N_LAYER (N_LAYER),
  .MIN_THR (MIN_THR)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_i         (op_i),
  .road_valid_o (road_valid_o),
  .road_addr_o  (road_addr_o),
  .empty_o      (empty_o),
  .thr_q        (thr_q)
);

// File: tb/test_am_road_matcher.sv
module test_am_road_matcher;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [6:0]  addr_i = '0;
  logic [2:0]  sel_i = '0;
  logic [11:0] data_i = '0;
  logic [11:0] data_o;
  logic        road_valid_o;
  logic [6:0]  road_addr_o;
  logic        empty_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  am_road_matcher i_am_road_matcher (
    .clk_i, .rst_ni, .op_i, .addr_i, .sel_i, .data_i,
    .data_o, .road_valid_o, .road_addr_o, .empty_o
  );

  function automatic logic [11:0] w(int p, int l);
    return {l[2:0], 2'b01, p[6:0]};
  endfunction

  function automatic logic [11:0] c(int l);
    return {3'b111, 2'b10, 4'b0000, l[2:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // command applied at a falling edge, taken at the next rising edge
  task automatic cmd(int op, int a, int s, int d);
    @(negedge clk_i);
    op_i = op[3:0]; addr_i = a[6:0]; sel_i = s[2:0]; data_i = d[11:0];
    @(negedge clk_i);
    op_i = 4'd0;
  endtask

  task automatic road(string req, int v, int a);
    chk({req, " valid"}, int'(road_valid_o), v);
    chk({req, " empty"}, int'(empty_o), 1 - v);
    if (v == 1) chk({req, " addr"}, int'(road_addr_o), a);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 valid", int'(road_valid_o), 0);
    chk("R1 data", int'(data_o), 0);
    rst_ni = 1'b1;

    // R2 load every word, read every word back
    for (int p = 0; p < 128; p++)
      for (int l = 0; l < 6; l++) cmd(1, p, l, int'(w(p, l)));
    for (int p = 0; p < 128; p++)
      for (int l = 0; l < 6; l++) begin
        cmd(2, p, l, 0);
        chk("R2 readback", int'(data_o), int'(w(p, l)));
      end
    cmd(0, 0, 0, 0);
    chk("R2 data holds", int'(data_o), int'(w(127, 5)));

    // R5 / R12 default threshold 6: road only with the sixth layer
    for (int l = 0; l < 5; l++) cmd(3, 0, l, int'(w(9, l)));
    road("R5 five of six", 0, 0);
    cmd(3, 0, 5, int'(w(9, 5)));
    road("R12 road after last hit", 1, 9);
    // R4 flags held through idle/read/write
    cmd(0, 0, 0, 0);
    cmd(2, 3, 0, 0);
    cmd(1, 127, 0, int'(w(127, 0)));
    road("R4 held", 1, 9);

    // R1 default threshold is 6, R6 thresholds 4/5/6 sweep
    for (int k = 4; k <= 6; k++) begin
      cmd(4, 0, 0, 0);
      cmd(6, 0, 0, k);
      for (int l = 0; l < k - 1; l++) cmd(3, 0, l, int'(w(33, l)));
      road("R6 below threshold", 0, 0);
      cmd(3, 0, k - 1, int'(w(33, k - 1)));
      road("R6 at threshold", 1, 33);
    end

    // R6 out-of-range values ignored; applies at once to held flags
    cmd(4, 0, 0, 0);
    cmd(6, 0, 0, 4);
    for (int l = 0; l < 4; l++) cmd(3, 0, l, int'(w(33, l)));
    road("R6 thr4", 1, 33);
    cmd(6, 0, 0, 3);
    road("R6 value 3 ignored", 1, 33);
    cmd(6, 0, 0, 7);
    road("R6 value 7 ignored", 1, 33);
    cmd(6, 0, 0, 5);
    road("R6 raised to 5", 0, 0);
    cmd(6, 0, 0, 4);

    // R3 word on the wrong layer sets no flag
    cmd(4, 0, 0, 0);
    for (int l = 0; l < 3; l++) cmd(3, 0, l, int'(w(20, l)));
    cmd(3, 0, 3, int'(w(20, 1)));
    road("R3 wrong layer", 0, 0);
    cmd(3, 0, 3, int'(w(20, 3)));
    road("R3 right layer", 1, 20);

    // R4 repeated hits on one layer count once
    cmd(4, 0, 0, 0);
    for (int i = 0; i < 4; i++) cmd(3, 0, 0, int'(w(9, 0)));
    for (int i = 0; i < 2; i++) cmd(3, 0, 1, int'(w(9, 1)));
    road("R4 duplicates count once", 0, 0);

    // R11 selects 6 and 7 ignored
    cmd(4, 0, 0, 0);
    for (int l = 0; l < 3; l++) cmd(3, 0, l, int'(w(50, l)));
    cmd(3, 0, 7, int'(w(50, 3)));
    cmd(3, 0, 6, int'(w(50, 3)));
    road("R11 hit sel 6/7", 0, 0);
    cmd(1, 5, 6, 12'h123);
    cmd(1, 5, 7, 12'h456);
    for (int l = 0; l < 6; l++) begin
      cmd(2, 5, l, 0);
      chk("R11 write sel 6/7", int'(data_o), int'(w(5, l)));
    end
    cmd(2, 5, 6, 0);
    chk("R11 read sel 6", int'(data_o), 0);

    // R10 one hit matches several patterns; R7/R8 ordered drain
    cmd(6, 0, 0, 6);
    cmd(4, 0, 0, 0);
    for (int l = 0; l < 6; l++) begin
      cmd(1, 100, l, int'(c(l)));
      cmd(1, 40, l, int'(c(l)));
      cmd(1, 70, l, int'(c(l)));
    end
    road("R4 write keeps roads", 0, 0);
    for (int l = 0; l < 6; l++) cmd(3, 0, l, int'(c(l)));
    road("R10 R7 first road", 1, 40);
    cmd(5, 0, 0, 0);
    road("R8 R7 second road", 1, 70);
    cmd(5, 0, 0, 0);
    road("R8 R7 third road", 1, 100);
    cmd(5, 0, 0, 0);
    road("R8 drained", 0, 0);
    cmd(5, 0, 0, 0);
    road("R8 pop on empty", 0, 0);
    // R8 retired stays retired until end of event
    cmd(3, 0, 0, int'(c(0)));
    road("R8 retired stays", 0, 0);

    // R9 end of event clears flags, keeps words
    cmd(4, 0, 0, 0);
    cmd(6, 0, 0, 4);
    for (int l = 0; l < 3; l++) cmd(3, 0, l, int'(c(l)));
    road("R9 flags cleared", 0, 0);
    cmd(3, 0, 3, int'(c(3)));
    road("R9 re-armed", 1, 40);
    cmd(4, 0, 0, 0);
    road("R9 clear", 0, 0);
    cmd(2, 40, 3, 0);
    chk("R9 words kept", int'(data_o), int'(c(3)));
    cmd(2, 9, 2, 0);
    chk("R9 words kept", int'(data_o), int'(w(9, 2)));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule